// File: doc/BRIEF.md
# Exception entry state update unit

This unit applies the architected state changes of a core on the clock edge where a system-call exception or a debug exception is accepted. Each cycle it decides whether either exception is taken. When one is, it picks the return address, copies the machine state register (MSR) into the matching save pair and rewrites selected MSR bits. It sets the syndrome register for a system call and forms the handler fetch address from a 32-bit prefix. A one-cycle valid strobe goes with that fetch address.

The pipeline supplies three addresses: the excepting instruction, the next sequential instruction, and the instruction it would have fetched had no exception occurred. It also supplies a 4-bit debug cause code, a debug-status summary, the internal-debug-mode enable and a flag for a pending exception of higher priority. A separate load port lets retiring instructions write the MSR. An exception entry on the same edge overrides that load.

Bits are numbered with bit 0 as the most significant, so big-endian bit b is vector index 31-b. The MSR fields, by big-endian bit, are: 6 vector unit available, 13 wait enable, 14 critical enable, 16 external enable, 17 user mode, 18 FPU available, 19 machine-check enable, 20 FP mode 0, 22 debug enable, 23 FP mode 1, 26 instruction space, 27 data space, 29 performance mark, 30 recoverable.

Top module: `exc_entry_unit`

## Requirements
- R1: A system-call entry is taken when `sc_exec` is 1, `hi_pri_pend` is 0, and no debug entry is taken in the same cycle.
- R2: On system-call entry, `sv_addr` takes `next_pc` and `sv_state` takes the MSR value from before the edge.
- R3: On system-call entry, the MSR clears big-endian bits 6, 13, 16, 17, 18, 20, 23, 26, 27 and 29. All other bits keep their values, including 14, 19, 22 and 30.
- R4: On system-call entry, `syn` becomes exactly big-endian bit 26 set, which is 32'h0000_0020. Nothing else writes `syn`.
- R5: A debug entry is taken when `dbg_hit`, `idm_en` and MSR big-endian bit 22 are all 1 and `hi_pri_pend` is 0.
- R6: On debug entry, `dsv_addr` is selected by `dbg_cause`. Codes 0 to 4 select `cur_pc`; they are instruction-address match, branch taken, return, critical return and trap. Codes 5 and 6 select `next_pc`; they are data-address match and instruction complete. Codes 7 to 15 select `resume_pc`; these include unconditional, interrupt taken, critical interrupt taken, counter and external event.
- R7: On debug entry, `dsv_state` takes the MSR from before the edge. The MSR clears big-endian bits 6, 13, 17, 18, 20, 22, 23, 26, 27 and 29. With the default `DBG_CLR_CE_EE`=1 it also clears bits 14 and 16. Other bits are kept. `syn`, `sv_addr` and `sv_state` are unchanged.
- R8: On any entry, `vec_addr` becomes the upper 24 bits of `vec_prefix` followed by 8'h80 for a system call or 8'h90 for debug. `vec_valid` is 1 for exactly the cycle after the entry edge.
- R9: When both entries qualify in one cycle, only the debug entry takes effect.
- R10: With no entry, all save registers, `syn` and `vec_addr` hold and `vec_valid` is 0. The MSR takes `msr_ld_val` if `msr_ld` is 1 and otherwise holds. An entry overrides `msr_ld`.
- R11: After reset every register output is 0 and `vec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sc_exec | input | 1 | A system-call instruction is executing |
| dbg_hit | input | 1 | Summary of the debug status bits; 1 if any is set |
| idm_en | input | 1 | Internal debug mode enable |
| hi_pri_pend | input | 1 | An exception of higher priority is pending |
| dbg_cause | input | 4 | Debug cause code |
| cur_pc | input | 32 | Address of the excepting instruction |
| next_pc | input | 32 | Address of the next sequential instruction |
| resume_pc | input | 32 | Address that would be fetched with no exception |
| vec_prefix | input | 32 | Vector prefix; the upper 24 bits are used |
| msr_ld | input | 1 | MSR load request from a retiring instruction |
| msr_ld_val | input | 32 | Value for the MSR load |
| msr | output | 32 | Machine state register |
| sv_addr | output | 32 | System-call return address |
| sv_state | output | 32 | System-call saved MSR |
| dsv_addr | output | 32 | Debug return address |
| dsv_state | output | 32 | Debug saved MSR |
| syn | output | 32 | Syndrome register |
| vec_addr | output | 32 | Handler fetch address |
| vec_valid | output | 1 | One-cycle strobe for `vec_addr` |

## Verification
The assertions assume that `rst_n` is held low for at least one edge before any checked cycle. They also assume that every input is stable around the rising edge, so a `$past` value is the value the design sampled. The stimulus meets both conditions: it changes inputs only on falling edges and starts with a multi-cycle reset. Before each trial it loads a known MSR through the load port. It then sweeps all sixteen cause codes against every combination of the qualifying flags, the debug-enable bit and the MSR load request.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN = 32;
  localparam int CAUSE_W = 4;

  localparam int BE_VEC  = 6;
  localparam int BE_WAIT = 13;
  localparam int BE_CRIT = 14;
  localparam int BE_EXT  = 16;
  localparam int BE_USER = 17;
  localparam int BE_FPU  = 18;
  localparam int BE_MCHK = 19;
  localparam int BE_FPM0 = 20;
  localparam int BE_DBG  = 22;
  localparam int BE_FPM1 = 23;
  localparam int BE_IS   = 26;
  localparam int BE_DS   = 27;
  localparam int BE_PERF = 29;
  localparam int BE_RECV = 30;
  localparam int BE_SYN_VLE = 26;

  localparam logic [7:0] OFS_SC  = 8'h80;
  localparam logic [7:0] OFS_DBG = 8'h90;

  typedef enum logic [1:0] {
    RET_CUR    = 2'd0,
    RET_NEXT   = 2'd1,
    RET_RESUME = 2'd2
  } ret_sel_e;

  function automatic int ix(input int be);
    return XLEN - 1 - be;
  endfunction

  function automatic logic [XLEN-1:0] be_bit(input int be);
    logic [XLEN-1:0] m;
    m = '0;
    m[XLEN-1-be] = 1'b1;
    return m;
  endfunction

  function automatic logic [XLEN-1:0] common_clr();
    return be_bit(BE_VEC) | be_bit(BE_WAIT) | be_bit(BE_USER) |
           be_bit(BE_FPU) | be_bit(BE_FPM0) | be_bit(BE_FPM1) |
           be_bit(BE_IS)  | be_bit(BE_DS)   | be_bit(BE_PERF);
  endfunction

  function automatic logic [XLEN-1:0] sc_clr();
    return common_clr() | be_bit(BE_EXT);
  endfunction

  function automatic logic [XLEN-1:0] dbg_clr(input bit clr_ce_ee);
    logic [XLEN-1:0] m;
    m = common_clr() | be_bit(BE_DBG);
    if (clr_ce_ee) m = m | be_bit(BE_CRIT) | be_bit(BE_EXT);
    return m;
  endfunction

  function automatic ret_sel_e cause_class(input logic [CAUSE_W-1:0] c);
    if (c <= 4'd4)      return RET_CUR;
    else if (c <= 4'd6) return RET_NEXT;
    else                return RET_RESUME;
  endfunction

  function automatic logic [XLEN-1:0] form_vec(input logic [XLEN-1:0] pfx,
                                               input logic [7:0] ofs);
    return {pfx[XLEN-1:8], ofs};
  endfunction
endpackage

// File: rtl/exc_qualify.sv
module exc_qualify (
  input  logic sc_exec,
  input  logic dbg_hit,
  input  logic idm_en,
  input  logic msr_de,
  input  logic hi_pri_pend,
  output logic sc_take,
  output logic dbg_take
);
  always_comb begin
    dbg_take = dbg_hit & idm_en & msr_de & ~hi_pri_pend;
    sc_take  = sc_exec & ~hi_pri_pend & ~dbg_take;
  end

  always_comb begin
    a_r9_one_winner: assert (!(sc_take && dbg_take));
  end
endmodule

// File: rtl/exc_ret_sel.sv
module exc_ret_sel
  import exc_entry_pkg::*;
(
  input  logic [CAUSE_W-1:0] cause,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic [XLEN-1:0]    next_pc,
  input  logic [XLEN-1:0]    resume_pc,
  output ret_sel_e           cls,
  output logic [XLEN-1:0]    ret_pc
);
  always_comb begin
    cls = cause_class(cause);
    unique case (cls)
      RET_CUR:  ret_pc = cur_pc;
      RET_NEXT: ret_pc = next_pc;
      default:  ret_pc = resume_pc;
    endcase
  end
endmodule

// File: rtl/exc_msr_rewrite.sv
module exc_msr_rewrite
  import exc_entry_pkg::*;
#(
  parameter bit DBG_CLR_CE_EE = 1'b1
) (
  input  logic [XLEN-1:0] msr_cur,
  output logic [XLEN-1:0] msr_sc,
  output logic [XLEN-1:0] msr_dbg
);
  localparam logic [XLEN-1:0] SC_MASK  = sc_clr();
  localparam logic [XLEN-1:0] DBG_MASK = dbg_clr(DBG_CLR_CE_EE);

  always_comb begin
    msr_sc  = msr_cur & ~SC_MASK;
    msr_dbg = msr_cur & ~DBG_MASK;
  end

  always_comb begin
    a_r3_mchk_kept: assert (msr_sc[ix(BE_MCHK)] == msr_cur[ix(BE_MCHK)]);
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter bit DBG_CLR_CE_EE = 1'b1,
  parameter logic [31:0] MSR_RST = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sc_exec,
  input  logic        dbg_hit,
  input  logic        idm_en,
  input  logic        hi_pri_pend,
  input  logic [3:0]  dbg_cause,
  input  logic [31:0] cur_pc,
  input  logic [31:0] next_pc,
  input  logic [31:0] resume_pc,
  input  logic [31:0] vec_prefix,
  input  logic        msr_ld,
  input  logic [31:0] msr_ld_val,
  output logic [31:0] msr,
  output logic [31:0] sv_addr,
  output logic [31:0] sv_state,
  output logic [31:0] dsv_addr,
  output logic [31:0] dsv_state,
  output logic [31:0] syn,
  output logic [31:0] vec_addr,
  output logic        vec_valid
);
  localparam logic [XLEN-1:0] SYN_SC = be_bit(BE_SYN_VLE);

  logic [XLEN-1:0] msr_q, sv_addr_q, sv_state_q, dsv_addr_q, dsv_state_q;
  logic [XLEN-1:0] syn_q, vec_q;
  logic            vec_v_q;

  logic            sc_take, dbg_take, any_take;
  logic [XLEN-1:0] dbg_ret_pc, msr_after_sc, msr_after_dbg;
  ret_sel_e        dbg_cls;

  exc_qualify u_qual (
    .sc_exec     (sc_exec),
    .dbg_hit     (dbg_hit),
    .idm_en      (idm_en),
    .msr_de      (msr_q[ix(BE_DBG)]),
    .hi_pri_pend (hi_pri_pend),
    .sc_take     (sc_take),
    .dbg_take    (dbg_take)
  );

  exc_ret_sel u_ret (
    .cause     (dbg_cause),
    .cur_pc    (cur_pc),
    .next_pc   (next_pc),
    .resume_pc (resume_pc),
    .cls       (dbg_cls),
    .ret_pc    (dbg_ret_pc)
  );

  exc_msr_rewrite #(.DBG_CLR_CE_EE(DBG_CLR_CE_EE)) u_msr (
    .msr_cur (msr_q),
    .msr_sc  (msr_after_sc),
    .msr_dbg (msr_after_dbg)
  );

  assign any_take = sc_take | dbg_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msr_q       <= MSR_RST;
      sv_addr_q   <= '0;
      sv_state_q  <= '0;
      dsv_addr_q  <= '0;
      dsv_state_q <= '0;
      syn_q       <= '0;
      vec_q       <= '0;
      vec_v_q     <= 1'b0;
    end else begin
      vec_v_q <= any_take;
      if (dbg_take) begin
        dsv_addr_q  <= dbg_ret_pc;
        dsv_state_q <= msr_q;
        msr_q       <= msr_after_dbg;
        vec_q       <= form_vec(vec_prefix, OFS_DBG);
      end else if (sc_take) begin
        sv_addr_q  <= next_pc;
        sv_state_q <= msr_q;
        msr_q      <= msr_after_sc;
        syn_q      <= SYN_SC;
        vec_q      <= form_vec(vec_prefix, OFS_SC);
      end else if (msr_ld) begin
        msr_q <= msr_ld_val;
      end
    end
  end

  assign msr       = msr_q;
  assign sv_addr   = sv_addr_q;
  assign sv_state  = sv_state_q;
  assign dsv_addr  = dsv_addr_q;
  assign dsv_state = dsv_state_q;
  assign syn       = syn_q;
  assign vec_addr  = vec_q;
  assign vec_valid = vec_v_q;

  a_r2_sc_save: assert property (@(posedge clk) disable iff (!rst_n)
    sc_take |=> (sv_addr_q == $past(next_pc)) && (sv_state_q == $past(msr_q)));

  a_r7_dbg_de_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_take |=> !msr_q[ix(BE_DBG)] &&
                 (msr_q[ix(BE_MCHK)] == $past(msr_q[ix(BE_MCHK)])) &&
                 $stable(syn_q));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_take && !msr_ld) |=> $stable(msr_q) && !vec_v_q && $stable(vec_q));

  a_r8_vec_offset: assert property (@(posedge clk) disable iff (!rst_n)
    vec_v_q |-> (vec_q[7:0] == OFS_SC) || (vec_q[7:0] == OFS_DBG));
endmodule

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sc_exec = 0, dbg_hit = 0, idm_en = 0, hi_pri_pend = 0, msr_ld = 0;
  logic [3:0]  dbg_cause = 0;
  logic [31:0] cur_pc = 0, next_pc = 0, resume_pc = 0, vec_prefix = 0, msr_ld_val = 0;
  logic [31:0] msr, sv_addr, sv_state, dsv_addr, dsv_state, syn, vec_addr;
  logic        vec_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  exc_entry_unit u_dut (
    .clk(clk), .rst_n(rst_n), .sc_exec(sc_exec), .dbg_hit(dbg_hit), .idm_en(idm_en),
    .hi_pri_pend(hi_pri_pend), .dbg_cause(dbg_cause), .cur_pc(cur_pc), .next_pc(next_pc),
    .resume_pc(resume_pc), .vec_prefix(vec_prefix), .msr_ld(msr_ld), .msr_ld_val(msr_ld_val),
    .msr(msr), .sv_addr(sv_addr), .sv_state(sv_state), .dsv_addr(dsv_addr),
    .dsv_state(dsv_state), .syn(syn), .vec_addr(vec_addr), .vec_valid(vec_valid)
  );

  function automatic logic [31:0] bb(input int b);
    return 32'h1 << (31 - b);
  endfunction

  logic [31:0] m_sc, m_dbg;
  initial begin
    m_sc  = '0;
    m_dbg = '0;
    foreach (sc_list[k])  m_sc  |= bb(sc_list[k]);
    foreach (dbg_list[k]) m_dbg |= bb(dbg_list[k]);
  end
  int sc_list[10]  = '{6, 13, 16, 17, 18, 20, 23, 26, 27, 29};
  int dbg_list[12] = '{6, 13, 14, 16, 17, 18, 20, 22, 23, 26, 27, 29};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic idle();
    sc_exec = 0; dbg_hit = 0; idm_en = 0; hi_pri_pend = 0; msr_ld = 0;
  endtask

  logic [31:0] e_msr, e_sva, e_svs, e_dsa, e_dss, e_syn, e_vec;

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 msr", msr, 0); chk("R11 sv_addr", sv_addr, 0); chk("R11 sv_state", sv_state, 0);
    chk("R11 dsv_addr", dsv_addr, 0); chk("R11 dsv_state", dsv_state, 0);
    chk("R11 syn", syn, 0); chk("R11 vec_addr", vec_addr, 0); chk("R11 vec_valid", {31'b0, vec_valid}, 0);
    rst_n = 1'b1;
    e_msr = 0; e_sva = 0; e_svs = 0; e_dsa = 0; e_dss = 0; e_syn = 0; e_vec = 0;

    for (int i = 0; i < 1024; i++) begin
      logic [31:0] v;
      logic sc_t, dbg_t;
      string mtag;
      v = i * 32'h9E3779B9;
      v[31-22] = i[8];
      msr_ld = 1; msr_ld_val = v;
      @(negedge clk);
      e_msr = v;
      chk("R10 msr load", msr, e_msr);

      dbg_cause = i[3:0]; sc_exec = i[4]; dbg_hit = i[5]; idm_en = i[6];
      hi_pri_pend = i[7]; msr_ld = i[9]; msr_ld_val = ~v;
      cur_pc = 32'h4000_0000 | (i << 4);
      next_pc = cur_pc + 32'd2;
      resume_pc = cur_pc ^ 32'h00F0_0008;
      vec_prefix = 32'hFFFF_F0A5 ^ (i << 12);

      dbg_t = i[5] & i[6] & i[8] & ~i[7];
      sc_t  = i[4] & ~i[7] & ~dbg_t;
      if (dbg_t) begin
        e_dss = e_msr;
        if (i[3:0] < 5) e_dsa = cur_pc;
        else if (i[3:0] < 7) e_dsa = next_pc;
        else e_dsa = resume_pc;
        e_msr = e_msr & ~m_dbg;
        e_vec = {vec_prefix[31:8], 8'h90};
        mtag = "R7 msr";
      end else if (sc_t) begin
        e_svs = e_msr; e_sva = next_pc;
        e_msr = e_msr & ~m_sc;
        e_syn = 32'h0000_0020;
        e_vec = {vec_prefix[31:8], 8'h80};
        mtag = "R3 msr";
      end else begin
        if (i[9]) e_msr = ~v;
        mtag = "R10 msr";
      end
      @(negedge clk);
      chk(mtag, msr, e_msr);
      chk(dbg_t ? "R9 sv_addr" : "R2 sv_addr", sv_addr, e_sva);
      chk("R2 sv_state", sv_state, e_svs);
      chk(dbg_t ? "R7 syn" : "R4 syn", syn, e_syn);
      chk(dbg_t ? "R6 dsv_addr" : "R5 dsv_addr", dsv_addr, e_dsa);
      chk("R7 dsv_state", dsv_state, e_dss);
      chk(sc_t ? "R1 vec_valid" : "R5 vec_valid", {31'b0, vec_valid}, {31'b0, sc_t | dbg_t});
      chk("R8 vec_addr", vec_addr, e_vec);
      idle();
      @(negedge clk);
      chk("R8 vec_valid pulse", {31'b0, vec_valid}, 0);
      chk("R10 idle msr", msr, e_msr);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule